// File: doc/BRIEF.md
# Debug Request/Response Mailbox

This block sits between a simple register port driven by a bus host and the request/response port of a core's debug module. The host fills two request registers (target address and write data), then writes an opcode register. That opcode write is the trigger: the mailbox raises a request toward the debug module and holds it until the module accepts it.

When the debug module answers, the mailbox latches the returned data word and result code and raises a pending flag in its status register. The host reads the result and then writes the status register to release the mailbox for the next request. Read and write requests use the same release step.

The status word carries two flags. The "free" flag (bit 0) tells the host a new request may be issued. The "answer waiting" flag (bit 1) tells it a response is held.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, status reads 1 (free set, answer-waiting clear), the address, data, opcode and response registers read 0, req_valid is 0 and rsp_ready is 0.
- R2: Word offsets are 0x800 request address, 0x804 request data, 0x808 request opcode (bits 1:0), 0x80C response data, 0x810 response opcode (bits 1:0), 0x814 status (bit 0 free, bit 1 answer waiting). A read of any other offset returns 0. The request registers read back the last accepted write.
- R3: A write to 0x808 while free is set stores bits 1:0 as the opcode (0 no operation, 1 read, 2 write). From the next cycle free is clear, and req_valid is 1 with req_addr, req_data and req_op equal to the stored registers.
- R4: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr, req_data and req_op stay unchanged. In the cycle after a cycle where req_valid and req_ready are both 1, req_valid is 0.
- R5: While free is clear, writes to 0x800, 0x804 and 0x808 are ignored. Register contents and the request outputs are unchanged, and no new request is raised.
- R6: rsp_ready is 1 exactly while a request is outstanding (free clear) and no answer is waiting. On a cycle with rsp_valid and rsp_ready both 1, rsp_data and rsp_op are captured into 0x80C and 0x810 (result codes 0 success, 1 failed, 2 busy), and status reads 2 from the next cycle.
- R7: While an answer is waiting, rsp_ready is 0 and further rsp_valid pulses do not change the captured response.
- R8: Any write to 0x814 while an answer is waiting clears answer-waiting and sets free, so status reads 1 from the next cycle. A write to 0x814 with no answer waiting changes nothing.
- R9: Writes to 0x80C and 0x810 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| req_valid | output | 1 | Request presented to debug module |
| req_ready | input | 1 | Debug module accepts request |
| req_addr | output | DATA_W | Request target address |
| req_data | output | DATA_W | Request write data |
| req_op | output | OP_W | Request opcode |
| rsp_valid | input | 1 | Debug module presents a response |
| rsp_ready | output | 1 | Mailbox can take a response |
| rsp_data | input | DATA_W | Response data |
| rsp_op | input | OP_W | Response result code |

## Verification
On every cycle, the assertions check several properties: that a launched request stays stable until it is accepted, that a response handshake lands in the capture registers, that an opcode write while busy leaves the registers untouched, that a release write restores the free flag, and that the two flags are never set together. Only the bench scenarios can show the things that depend on what the host reads back. These are the decoded register map, zero for unmapped offsets, the ignored writes to result registers, and the full request–answer–release cycle across every opcode, every result code and several accept delays.

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int OP_W   = 2,
  parameter logic [ADDR_W-1:0] BASE = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [OP_W-1:0]   req_op,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [OP_W-1:0]   rsp_op
);
  localparam logic [ADDR_W-1:0] A_RA = BASE;
  localparam logic [ADDR_W-1:0] A_RD = BASE + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OP = BASE + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_XD = BASE + ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_XO = BASE + ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_ST = BASE + ADDR_W'(20);

  logic              free_q, wait_q;
  logic [DATA_W-1:0] ra_q, rd_q, xd_q;
  logic [OP_W-1:0]   op_q, xo_q;

  wire hit_ra = bus_wr && bus_addr == A_RA;
  wire hit_rd = bus_wr && bus_addr == A_RD;
  wire hit_op = bus_wr && bus_addr == A_OP;
  wire hit_st = bus_wr && bus_addr == A_ST;
  wire launch = hit_op && free_q;
  wire ack    = hit_st && wait_q;
  wire take   = rsp_valid && rsp_ready;

  assign rsp_ready = !free_q && !wait_q;
  assign req_addr  = ra_q;
  assign req_data  = rd_q;
  assign req_op    = op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_q    <= 1'b1;
      wait_q    <= 1'b0;
      req_valid <= 1'b0;
      ra_q      <= '0;
      rd_q      <= '0;
      op_q      <= '0;
      xd_q      <= '0;
      xo_q      <= '0;
    end else begin
      if (hit_ra && free_q) ra_q <= bus_wdata;
      if (hit_rd && free_q) rd_q <= bus_wdata;
      if (launch) begin
        op_q      <= bus_wdata[OP_W-1:0];
        free_q    <= 1'b0;
        req_valid <= 1'b1;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (take) begin
        xd_q   <= rsp_data;
        xo_q   <= rsp_op;
        wait_q <= 1'b1;
      end
      if (ack) begin
        wait_q <= 1'b0;
        free_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_RA:    bus_rdata = ra_q;
      A_RD:    bus_rdata = rd_q;
      A_OP:    bus_rdata = DATA_W'(op_q);
      A_XD:    bus_rdata = xd_q;
      A_XO:    bus_rdata = DATA_W'(xo_q);
      A_ST:    bus_rdata = DATA_W'({wait_q, free_q});
      default: bus_rdata = '0;
    endcase
  end

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_op && free_q |=> req_valid && !free_q);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_op));

  // R5
  busy_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !free_q |=> $stable(op_q) && $stable(ra_q) && $stable(rd_q));

  // R6
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> wait_q && xd_q == $past(rsp_data) && xo_q == $past(rsp_op));

  // R7
  flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> !free_q && !rsp_ready);

  // R8
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_st && wait_q |=> !wait_q && free_q);
endmodule

// File: tb/dbg_mailbox_tb.sv
module dbg_mailbox_tb;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        req_valid, req_ready = 0, rsp_valid = 0, rsp_ready;
  logic [31:0] req_addr, req_data, rsp_data = 0;
  logic [1:0]  req_op, rsp_op = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_mailbox u_dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
    .req_valid, .req_ready, .req_addr, .req_data, .req_op,
    .rsp_valid, .rsp_ready, .rsp_data, .rsp_op);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(string tag, logic [11:0] a, logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdchk("R1 status", 12'h814, 1);
    rdchk("R1 addr", 12'h800, 0);
    rdchk("R1 data", 12'h804, 0);
    rdchk("R1 op", 12'h808, 0);
    rdchk("R1 rspd", 12'h80C, 0);
    rdchk("R1 rspo", 12'h810, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 rsp_ready", rsp_ready, 0);
    // R2 unmapped offsets
    rdchk("R2 unmapped 7FC", 12'h7FC, 0);
    rdchk("R2 unmapped 818", 12'h818, 0);
    rdchk("R2 unmapped 000", 12'h000, 0);
    // R8 release with nothing waiting
    wr(12'h814, 32'hFFFF_FFFF);
    rdchk("R8 idle ack", 12'h814, 1);
    chk("R8 idle ack req", req_valid, 0);

    for (int op = 0; op < 3; op++)
      for (int ro = 0; ro < 3; ro++)
        for (int st = 0; st < 3; st++) begin
          automatic int k = op * 9 + ro * 3 + st;
          automatic logic [31:0] a = 32'h1000_0000 + 32'(k) * 32'h0111;
          automatic logic [31:0] d = ~a ^ (32'(k) << 20);
          automatic logic [31:0] x = a * 3 + 32'(k);
          rdchk("R8 free before", 12'h814, 1);
          wr(12'h800, a);
          wr(12'h804, d);
          rdchk("R2 addr rb", 12'h800, a);
          rdchk("R2 data rb", 12'h804, d);
          wr(12'h808, 32'(op) | 32'hFFFF_FFFC);
          // R3 launch
          chk("R3 valid", req_valid, 1);
          chk("R3 addr", req_addr, a);
          chk("R3 data", req_data, d);
          chk("R3 op", 32'(req_op), 32'(op));
          rdchk("R3 status", 12'h814, 0);
          rdchk("R2 op rb", 12'h808, 32'(op));
          chk("R6 ready", rsp_ready, 1);
          // R5 writes while busy are ignored
          wr(12'h808, 32'(op + 1));
          wr(12'h800, 32'hDEAD_0000);
          wr(12'h804, 32'hBEEF_0000);
          rdchk("R5 op", 12'h808, 32'(op));
          rdchk("R5 addr", 12'h800, a);
          rdchk("R5 data", 12'h804, d);
          chk("R5 req_addr", req_addr, a);
          // R4 hold for st extra cycles
          for (int c = 0; c < st; c++) begin
            @(negedge clk);
            chk("R4 held", req_valid, 1);
            chk("R4 stable", req_data, d);
          end
          req_ready = 1;
          @(negedge clk);
          req_ready = 0;
          chk("R4 dropped", req_valid, 0);
          // R6 capture
          rsp_valid = 1; rsp_data = x; rsp_op = 2'(ro);
          @(negedge clk);
          rsp_valid = 0;
          rdchk("R6 status", 12'h814, 2);
          rdchk("R6 rspd", 12'h80C, x);
          rdchk("R6 rspo", 12'h810, 32'(ro));
          // R7 second response blocked
          chk("R7 not ready", rsp_ready, 0);
          rsp_valid = 1; rsp_data = ~x; rsp_op = 2'(ro + 1);
          @(negedge clk);
          rsp_valid = 0;
          rdchk("R7 rspd", 12'h80C, x);
          rdchk("R7 rspo", 12'h810, 32'(ro));
          // R9 result registers read-only
          wr(12'h80C, 32'h5555_AAAA);
          wr(12'h810, 32'h3);
          rdchk("R9 rspd", 12'h80C, x);
          rdchk("R9 rspo", 12'h810, 32'(ro));
          // R8 release
          wr(12'h814, 32'(k));
          rdchk("R8 status", 12'h814, 1);
          chk("R6 idle not ready", rsp_ready, 0);
        end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule